// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that finishes one instruction per clock period. At each active edge it commits the result of the instruction fetched at the current program counter and moves to the next one. It has a program counter, a 32-entry register file with two combinational read ports and one write port, an ALU, a sign extender and a main decoder. It also has its own instruction and data word arrays. Multiplexers steer the operands and the write-back data, so the same datapath serves register arithmetic, word loads and stores, equal-compare branches and absolute jumps. A separate adder forms PC+4, so that address arithmetic and the ALU can both work in the same cycle.

The two word arrays are filled through a preload port while reset is held. The core then starts from address 0 when reset is released. For every instruction, the core shows its committed effects on observation ports: the current PC, the register write (enable, index, value) and the data-memory store (enable, byte address, value). Each of these describes the instruction that the next rising edge will retire.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0. The first instruction executed after reset is released is the one at byte address 0.
- R2: After any instruction other than a taken branch or a jump, the PC advances by 4.
- R3: An R-type instruction (opcode 0, shamt 0) writes register rd with rs op rt. The funct codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A set-less-than. Set-less-than is a signed compare and gives 1 or 0.
- R4: Register 0 always reads as zero. A write aimed at it changes nothing, and `rf_we_o` stays low for that write.
- R5: Load word (opcode 0x23) writes rt with the data word at rs plus the sign-extended 16-bit offset in bits 15:0.
- R6: Store word (opcode 0x2B) writes the value of rt to the data word at rs plus the sign-extended offset. A store writes no register.
- R7: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended offset times 4 when rs equals rt. Otherwise the next PC is PC+4. A branch writes neither a register nor memory.
- R8: Jump (opcode 0x02) sets the next PC to bits 31:28 of PC+4, followed by the 26-bit target in bits 25:0, followed by two zero bits.
- R9: Any other opcode, and an R-type with an unknown funct or a nonzero shamt, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data array, 0 instruction array |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | A register is written at the next edge |
| rf_waddr_o | output | 5 | Index of the register written |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | Data memory is written at the next edge |
| dm_addr_o | output | 32 | Byte address of the store |
| dm_wdata_o | output | 32 | Store data |

## Verification
The observation ports are combinational from the PC register. The effects of an instruction are therefore visible in the same cycle the PC points at it, and they take hold at the next rising edge. The next PC shows up one edge later. The scoreboard runs its own instruction-level model over the encoded program and queues one expected item per instruction. The monitor pops one item per cycle at the falling edge: the first right after reset is released, then one after each later rising edge. It compares the PC, which reflects the control decision of the previous item, and the write and store fields of the current item.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    src_imm;
    logic    mem_we;
    logic    wb_mem;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] alu_fn(input alu_op_e op,
                                             input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] br_target(input logic [XLEN-1:0] pc4,
                                                input logic [15:0] off);
    return pc4 + {sext16(off)[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jmp_target(input logic [XLEN-1:0] pc4,
                                                 input logic [25:0] tgt);
    return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
  endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = (shamt == 5'd0);
        case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we  = 1'b1;
        ctrl.src_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J:    ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  // R9: at most one kind of architectural effect per instruction
  always_comb begin
    if (!$isunknown(opcode))
      assert_ctrl_onehot_R9: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.branch, ctrl.jump}));
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] regs [NREG];
  logic         wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R3: a live write is visible in storage one edge later
  assert_write_lands_R3: assert property (@(posedge clk)
    wr_live |=> regs[$past(waddr)] == $past(wdata));

  // R4: index zero always reads back zero
  always_comb begin
    if (ra1 == '0) assert_r0_reads_zero_R4: assert (rd1 == '0);
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  assign y    = alu_fn(op, a, b);
  assign zero = (y == '0);

  // R3: set-less-than yields only 0 or 1
  always_comb begin
    if (op == ALU_SLT) assert_slt_bool_R3: assert (y[XLEN-1:1] == '0);
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW   = $clog2(IMEM_WORDS),
  localparam int DAW   = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [31:0]      ld_data,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc4, pc_next, instr;
  logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, dm_rdata, wb_data;
  logic [4:0]      waddr;
  logic            alu_zero, br_taken, rf_we, st_we;
  ctrl_t           ctrl;

  // fetch
  assign instr = imem[pc_q[IAW+1:2]];
  assign pc4   = pc_q + 32'd4;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .shamt  (instr[10:6]),
    .ctrl   (ctrl)
  );

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_we = ctrl.reg_we && rst_n;

  sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (waddr),
    .wdata (wb_data),
    .ra1   (instr[25:21]),
    .ra2   (instr[20:16]),
    .rd1   (rs_val),
    .rd2   (rt_val)
  );

  assign imm_x = sext16(instr[15:0]);
  assign alu_b = ctrl.src_imm ? imm_x : rt_val;

  sc_alu u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: combinational read, write at the edge
  assign st_we    = ctrl.mem_we && rst_n;
  assign dm_rdata = dmem[alu_y[DAW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)  dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (st_we)        dmem[alu_y[DAW+1:2]]   <= rt_val;
  end

  assign wb_data = ctrl.wb_mem ? dm_rdata : alu_y;

  // next PC
  assign br_taken = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)     pc_next = jmp_target(pc4, instr[25:0]);
    else if (br_taken) pc_next = br_target(pc4, instr[15:0]);
    else               pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we && (waddr != 5'd0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = st_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  assert_pc_reset_R1: assert property (@(posedge clk)
    !rst_n |=> pc_q == '0);

  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.jump && !br_taken) |=> pc_q == $past(pc_q) + 32'd4);

  assert_beq_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_x[29:0]), 2'b00});

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.jump |=> pc_q == {$past(pc4[31:28]), $past(instr[25:0]), 2'b00});

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we_o |-> !rf_we_o);

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

  localparam int LD_AW = 6;
  localparam int NSTEP = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ld_en = 1'b0, ld_dmem = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [31:0]      pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]       rf_waddr_o;
  logic             rf_we_o, dm_we_o;

  always #4 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        mwe;
    logic [31:0] ma;
    logic [31:0] md;
    int          req;
    int          pc_req;
  } exp_t;

  exp_t        sbq[$];
  int          n_chk = 0, n_bad = 0;
  logic [31:0] prog [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];

  function automatic string tag(input int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic load_word(input logic dm, input int idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = dm; ld_addr = LD_AW'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // driver: an instruction-level model of the requirements fills the queue
  task automatic build_expected();
    logic [31:0] pc = 32'd0, w, a, b, sx, res, pc4, npc;
    int pc_req = 1;
    for (int k = 0; k < NSTEP; k++) begin
      exp_t e;
      logic [5:0] op, fn;
      int rs, rt, rd;
      w  = prog[pc[7:2]];
      op = w[31:26]; fn = w[5:0];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      a  = (rs == 0) ? 32'd0 : m_rf[rs];
      b  = (rt == 0) ? 32'd0 : m_rf[rt];
      sx = {{16{w[15]}}, w[15:0]};
      pc4 = pc + 4; npc = pc4;
      e = '{pc: pc, we: 1'b0, wa: 5'd0, wd: 32'd0, mwe: 1'b0, ma: 32'd0,
            md: 32'd0, req: 9, pc_req: pc_req};
      pc_req = 2;
      if (op == 6'h00 && w[10:6] == 5'd0 &&
          (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        e.req = (rd == 0 || rs == 0) ? 4 : 3;
        if (rd != 0) begin
          e.we = 1'b1; e.wa = 5'(rd); e.wd = res; m_rf[rd] = res;
        end
      end else if (op == 6'h23) begin
        res = m_dm[(a + sx) >> 2];
        e.req = 5;
        if (rt != 0) begin
          e.we = 1'b1; e.wa = 5'(rt); e.wd = res; m_rf[rt] = res;
        end
      end else if (op == 6'h2B) begin
        e.req = 6; e.mwe = 1'b1; e.ma = a + sx; e.md = b;
        m_dm[(a + sx) >> 2] = b;
      end else if (op == 6'h04) begin
        e.req = 7; pc_req = 7;
        if (a == b) npc = pc4 + (sx << 2);
      end else if (op == 6'h02) begin
        e.req = 8; pc_req = 8;
        npc = {pc4[31:28], w[25:0], 2'b00};
      end
      sbq.push_back(e);
      pc = npc;
    end
  endtask

  task automatic compare(input exp_t e);
    string r = tag(e.req);
    check(tag(e.pc_req), "pc", pc_o, e.pc);
    check(r, "reg write enable", 32'(rf_we_o), 32'(e.we));
    if (e.we) begin
      check(r, "reg index", 32'(rf_waddr_o), 32'(e.wa));
      check(r, "reg data", rf_wdata_o, e.wd);
    end
    check(r, "store enable", 32'(dm_we_o), 32'(e.mwe));
    if (e.mwe) begin
      check(r, "store address", dm_addr_o, e.ma);
      check(r, "store data", dm_wdata_o, e.md);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin prog[i] = 32'hFC00_0000; m_dm[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
    m_dm[0] = 32'd7; m_dm[1] = 32'hFFFF_FFFD; m_dm[2] = 32'h0F0F_00FF; m_dm[3] = 32'h1234_5678;
    prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
    prog[2]  = enc_i(6'h23, 0, 3, 16'd8);
    prog[3]  = enc_i(6'h23, 0, 4, 16'd12);
    prog[4]  = enc_r(1, 2, 5, 6'h20);
    prog[5]  = enc_r(1, 2, 6, 6'h22);
    prog[6]  = enc_r(3, 4, 7, 6'h24);
    prog[7]  = enc_r(3, 4, 8, 6'h25);
    prog[8]  = enc_r(2, 1, 9, 6'h2A);   // R3 signed: -3 < 7
    prog[9]  = enc_r(1, 2, 10, 6'h2A);
    prog[10] = enc_r(1, 1, 0, 6'h20);   // R4 write to r0 dropped
    prog[11] = enc_r(0, 1, 11, 6'h20);  // R4 r0 reads zero
    prog[12] = enc_i(6'h2B, 1, 5, 16'd9);
    prog[13] = enc_i(6'h23, 0, 12, 16'd16);
    prog[14] = enc_i(6'h23, 11, 13, 16'hFFF9); // R5 negative offset
    prog[15] = enc_i(6'h04, 1, 2, 16'd5);      // R7 not taken
    prog[16] = enc_i(6'h04, 1, 11, 16'd2);     // R7 taken
    prog[17] = enc_r(1, 1, 14, 6'h20);
    prog[18] = enc_r(1, 1, 15, 6'h20);
    prog[19] = {6'h02, 26'd22};                // R8
    prog[20] = enc_r(1, 1, 16, 6'h20);
    prog[21] = enc_r(1, 1, 17, 6'h20);
    prog[22] = 32'hFC00_0000;                  // R9 unknown opcode
    prog[23] = enc_r(1, 2, 18, 6'h3F);         // R9 unknown funct
    prog[24] = {6'h00, 5'd1, 5'd2, 5'd19, 5'd3, 6'h20}; // R9 nonzero shamt
    prog[25] = enc_i(6'h04, 0, 0, 16'hFFFF);   // R7 backward self-loop

    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) load_word(1'b0, i, prog[i]);
    for (int i = 0; i < 4; i++) load_word(1'b1, i, m_dm[i]);
    build_expected();

    @(negedge clk); #1;
    check("R1", "pc in reset", pc_o, 32'd0);
    check("R1", "no store in reset", 32'(dm_we_o), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // monitor: one item per cycle, sampled at the falling edge
    while (sbq.size() > 0) begin
      compare(sbq.pop_front());
      @(negedge clk); #1;
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule